// File: doc/BRIEF.md
# Recovered-Clock Frequency Lock Monitor

This block decides whether a recovered clock is running at the same rate as a trusted reference clock. In the reference domain it opens a gate of a fixed number of reference cycles. It measures how many recovered-clock edges arrived during that gate and compares the count with the gate length. If the two counts differ by more than a tolerance count, the gate is judged out of window. The default tolerance is 20 counts in a 4096-cycle gate, which is about half a percent either way. A free-running Gray-coded counter in the recovered domain is synchronised into the reference domain, so a count that is only partly updated is never captured.

A controller state machine turns the gate verdicts into a loss-of-lock alarm and a one-cycle reacquire request for the clock recovery loop. Its states are `ST_PRIME`, `ST_LOCKED`, `ST_SUSPECT`, `ST_HOLD` and `ST_WAIT`, and it moves between them as follows:

- **baseline:** `ST_PRIME` to `ST_LOCKED` on the first verdict, which only sets the baseline.
- **first miss:** `ST_LOCKED` to `ST_SUSPECT` on a bad verdict.
- **alarm raise:** `ST_SUSPECT` to `ST_HOLD` on a second consecutive bad verdict. The alarm rises and the request pulses.
- **forgive:** `ST_SUSPECT` to `ST_LOCKED` on a good verdict.
- **hold done:** `ST_HOLD` to `ST_WAIT` after the minimum alarm width.
- **release:** `ST_WAIT` to `ST_LOCKED` on a good verdict.

Requiring two bad gates in a row means the alarm can never rise sooner than a full gate after the recovered clock dies.

Top module: `freq_lock_monitor`

## Requirements
- R1: While reset is asserted and after it is released, `lock_lost` and `reacq_req` are 0. The first completed gate only sets the baseline and raises nothing.
- R2: A gate lasts `GATE_CYCLES` reference cycles. A gate is bad when the number of recovered edges in it differs from `GATE_CYCLES` by more than `TOL_COUNT`. A deviation of +0.3 % (about 12 counts) leaves the alarm low.
- R3: The alarm rises only after two consecutive bad gates. A single bad gate followed by a good one raises neither output. The alarm rise always follows a gate end by exactly two reference cycles.
- R4: `reacq_req` is high for exactly one reference cycle, in the same cycle that `lock_lost` rises, and at no other time.
- R5: Once raised, `lock_lost` stays high for at least `MIN_ALARM` (32) reference cycles.
- R6: After the minimum width, `lock_lost` stays high until the first good gate, and it falls two cycles after that gate's end.
- R7: A recovered clock 1 % fast or 1 % slow raises the alarm with a single request.
- R8: A stopped recovered clock raises the alarm, at least 250 reference cycles after it stopped. When the clock returns at the nominal rate, the alarm is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk | input | 1 | Reference clock; all decisions are made in this domain |
| rec_clk | input | 1 | Recovered clock under test |
| rst_n | input | 1 | Active-low asynchronous reset for both domains |
| lock_lost | output | 1 | Loss-of-lock alarm, reference domain |
| reacq_req | output | 1 | One-cycle request to force frequency and phase reacquisition |

## Verification
A wrong controller state appears on `lock_lost` at the next verdict, at most one gate plus two cycles later. Examples are an alarm that stays up after nominal rate returns, or one raised by a lone short gate. A corrupted baseline or synchroniser value shows as a spurious bad verdict in the following gate. A mis-sized hold counter shows as an alarm shorter than 32 cycles, or as a request pulse that is not aligned with the alarm's rising edge. The bench sweeps the recovered rate and also stops the clock, checking both the alarm level and the request pulse count in each window.

// File: rtl/flm_pkg.sv
`timescale 1ns/1ps
package flm_pkg;
    typedef enum logic [2:0] {
        ST_PRIME,
        ST_LOCKED,
        ST_SUSPECT,
        ST_HOLD,
        ST_WAIT
    } flm_state_e;
endpackage

// File: rtl/flm_gray_counter.sv
`timescale 1ns/1ps
module flm_gray_counter #(
    parameter int CNT_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] gray
);
    logic [CNT_W-1:0] bin_q;
    logic [CNT_W-1:0] bin_next;

    assign bin_next = bin_q + CNT_W'(1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bin_q <= '0;
            gray  <= '0;
        end else begin
            bin_q <= bin_next;
            gray  <= bin_next ^ (bin_next >> 1);
        end
    end
endmodule

// File: rtl/flm_gray_sync.sv
`timescale 1ns/1ps
module flm_gray_sync #(
    parameter int CNT_W  = 14,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] gray_in,
    output logic [CNT_W-1:0] bin_out
);
    logic [CNT_W-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stage_q[s] <= '0;
                end else if (s == 0) begin
                    stage_q[s] <= gray_in;
                end else begin
                    stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    always_comb begin
        bin_out[CNT_W-1] = stage_q[STAGES-1][CNT_W-1];
        for (int i = CNT_W-2; i >= 0; i--) begin
            bin_out[i] = bin_out[i+1] ^ stage_q[STAGES-1][i];
        end
    end
endmodule

// File: rtl/flm_gate_timer.sv
`timescale 1ns/1ps
module flm_gate_timer #(
    parameter int GATE_CYCLES = 4096
) (
    input  logic clk,
    input  logic rst_n,
    output logic gate_end
);
    localparam int GW = $clog2(GATE_CYCLES);
    localparam logic [GW-1:0] LAST = GW'(GATE_CYCLES - 1);

    logic [GW-1:0] cnt_q;

    assign gate_end = (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (gate_end) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + GW'(1);
        end
    end
endmodule

// File: rtl/flm_rate_judge.sv
`timescale 1ns/1ps
module flm_rate_judge #(
    parameter int CNT_W       = 14,
    parameter int GATE_CYCLES = 4096,
    parameter int TOL_COUNT   = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             gate_end,
    input  logic [CNT_W-1:0] rec_count,
    output logic             verdict_valid,
    output logic             verdict_bad
);
    localparam logic [CNT_W-1:0] EXPECT = CNT_W'(GATE_CYCLES);
    localparam logic [CNT_W-1:0] TOL    = CNT_W'(TOL_COUNT);

    logic [CNT_W-1:0] prev_q;
    logic [CNT_W-1:0] delta;
    logic [CNT_W-1:0] dev;

    assign delta = rec_count - prev_q;
    assign dev   = (delta >= EXPECT) ? (delta - EXPECT) : (EXPECT - delta);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q        <= '0;
            verdict_valid <= 1'b0;
            verdict_bad   <= 1'b0;
        end else begin
            verdict_valid <= gate_end;
            if (gate_end) begin
                prev_q      <= rec_count;
                verdict_bad <= (dev > TOL);
            end
        end
    end
endmodule

// File: rtl/freq_lock_monitor.sv
`timescale 1ns/1ps
module freq_lock_monitor #(
    parameter int GATE_CYCLES = 4096,
    parameter int TOL_COUNT   = 20,
    parameter int MIN_ALARM   = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic ref_clk,
    input  logic rec_clk,
    input  logic rst_n,
    output logic lock_lost,
    output logic reacq_req
);
    import flm_pkg::*;

    localparam int CNT_W  = $clog2(GATE_CYCLES) + 2;
    localparam int HOLD_W = $clog2(MIN_ALARM) + 1;
    localparam logic [HOLD_W-1:0] HOLD_LAST = HOLD_W'(MIN_ALARM - 1);

    logic [CNT_W-1:0]  rec_gray;
    logic [CNT_W-1:0]  rec_count;
    logic              gate_end;
    logic              verdict_valid;
    logic              verdict_bad;
    flm_state_e        state_q;
    flm_state_e        state_n;
    logic [HOLD_W-1:0] hold_q;

    flm_gray_counter #(.CNT_W(CNT_W)) u_rec_cnt (
        .clk   (rec_clk),
        .rst_n (rst_n),
        .gray  (rec_gray)
    );

    flm_gray_sync #(.CNT_W(CNT_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (ref_clk),
        .rst_n   (rst_n),
        .gray_in (rec_gray),
        .bin_out (rec_count)
    );

    flm_gate_timer #(.GATE_CYCLES(GATE_CYCLES)) u_gate (
        .clk      (ref_clk),
        .rst_n    (rst_n),
        .gate_end (gate_end)
    );

    flm_rate_judge #(
        .CNT_W       (CNT_W),
        .GATE_CYCLES (GATE_CYCLES),
        .TOL_COUNT   (TOL_COUNT)
    ) u_judge (
        .clk           (ref_clk),
        .rst_n         (rst_n),
        .gate_end      (gate_end),
        .rec_count     (rec_count),
        .verdict_valid (verdict_valid),
        .verdict_bad   (verdict_bad)
    );

    // next-state logic
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_PRIME:   if (verdict_valid) state_n = ST_LOCKED;
            ST_LOCKED:  if (verdict_valid && verdict_bad) state_n = ST_SUSPECT;
            ST_SUSPECT: if (verdict_valid) state_n = verdict_bad ? ST_HOLD : ST_LOCKED;
            ST_HOLD:    if (hold_q == HOLD_LAST) state_n = ST_WAIT;
            ST_WAIT:    if (verdict_valid && !verdict_bad) state_n = ST_LOCKED;
            default:    state_n = ST_PRIME;
        endcase
    end

    // state register and hold timer
    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_PRIME;
            hold_q  <= '0;
        end else begin
            state_q <= state_n;
            hold_q  <= (state_q == ST_HOLD) ? hold_q + HOLD_W'(1) : '0;
        end
    end

    // registered outputs
    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) begin
            lock_lost <= 1'b0;
            reacq_req <= 1'b0;
        end else begin
            lock_lost <= (state_n == ST_HOLD) || (state_n == ST_WAIT);
            reacq_req <= (state_q == ST_SUSPECT) && (state_n == ST_HOLD);
        end
    end
endmodule

// File: rtl/flm_checker.sv
`timescale 1ns/1ps
module flm_checker #(
    parameter int MIN_ALARM = 32
) (
    input logic clk,
    input logic rst_n,
    input logic gate_end,
    input logic lock_lost,
    input logic reacq_req
);
    localparam int HW = $clog2(MIN_ALARM) + 2;
    localparam logic [HW-1:0] SAT = {HW{1'b1}};

    logic [HW-1:0] high_run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            high_run_q <= '0;
        end else if (!lock_lost) begin
            high_run_q <= '0;
        end else if (high_run_q != SAT) begin
            high_run_q <= high_run_q + HW'(1);
        end
    end

    assert_min_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lock_lost) |-> (high_run_q >= HW'(MIN_ALARM)));

    assert_req_on_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_lost) |-> reacq_req);

    assert_req_only_on_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
        reacq_req |-> $rose(lock_lost));

    assert_req_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        reacq_req |=> !reacq_req);

    assert_rise_after_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_lost) |-> $past(gate_end, 2));

    assert_fall_after_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(lock_lost) |-> $past(gate_end, 2));
endmodule

bind freq_lock_monitor flm_checker #(.MIN_ALARM(MIN_ALARM)) u_checker (
    .clk       (ref_clk),
    .rst_n     (rst_n),
    .gate_end  (gate_end),
    .lock_lost (lock_lost),
    .reacq_req (reacq_req)
);

// File: tb/test_freq_lock_monitor.sv
`timescale 1ns/1ps
module test_freq_lock_monitor;
    localparam real REF_PERIOD = 10.0;
    localparam int  GATE       = 4096;
    localparam int  SETTLE     = 3*GATE + 100;
    localparam int  NVEC       = 6;
    // recovered half periods (ns): nominal, +0.3 %, +1 %, nominal, -1 %, nominal
    localparam real VEC_HALF  [NVEC] = '{5.0, 4.985, 4.95, 5.0, 5.05, 5.0};
    localparam bit  VEC_ALARM [NVEC] = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0};
    localparam int  VEC_REQS  [NVEC] = '{0, 0, 1, 0, 1, 0};

    logic ref_clk = 1'b0;
    logic rec_clk = 1'b0;
    logic rst_n   = 1'b0;
    logic lock_lost;
    logic reacq_req;

    real rec_half = 5.0;
    bit  rec_stop = 1'b0;
    bit  done     = 1'b0;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int req_cnt = 0;
    int rise_cnt = 0;
    int rise_cyc = 0;
    int hi_run = 0;
    int min_width = 1000000;
    bit prev_alarm = 1'b0;

    freq_lock_monitor i_freq_lock_monitor (
        .ref_clk   (ref_clk),
        .rec_clk   (rec_clk),
        .rst_n     (rst_n),
        .lock_lost (lock_lost),
        .reacq_req (reacq_req)
    );

    always #(REF_PERIOD/2.0) ref_clk = ~ref_clk;

    always begin
        #(rec_half);
        if (!rec_stop) rec_clk = ~rec_clk;
    end

    // port monitor, away from the active edge
    always @(negedge ref_clk) begin
        cyc <= cyc + 1;
        if (rst_n) begin
            if (reacq_req) req_cnt <= req_cnt + 1;
            if (lock_lost) begin
                hi_run <= hi_run + 1;
                if (!prev_alarm) begin
                    rise_cnt <= rise_cnt + 1;
                    rise_cyc <= cyc;
                end
            end else begin
                if (prev_alarm && hi_run < min_width) min_width <= hi_run;
                hi_run <= 0;
            end
            prev_alarm <= lock_lost;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_ref(input int n);
        repeat (n) @(posedge ref_clk);
        @(negedge ref_clk);
        #1;
    endtask

    initial begin
        int stop_cyc;
        int req_base;
        int rise_base;
        repeat (5) @(posedge ref_clk);
        @(negedge ref_clk);
        check(lock_lost == 1'b0, "R1 alarm in reset", int'(lock_lost), 0);
        check(reacq_req == 1'b0, "R1 request in reset", int'(reacq_req), 0);
        rst_n = 1'b1;
        wait_ref(GATE + 10);
        check(lock_lost == 1'b0 && req_cnt == 0, "R1 baseline gate raises nothing",
              int'(lock_lost) + req_cnt, 0);

        // rate sweep table (R2, R7, R6)
        for (int v = 0; v < NVEC; v++) begin
            req_base = req_cnt;
            rec_half = VEC_HALF[v];
            wait_ref(SETTLE);
            check(lock_lost == VEC_ALARM[v], $sformatf("R2/R7 alarm level vector %0d", v),
                  int'(lock_lost), int'(VEC_ALARM[v]));
            check(req_cnt - req_base == VEC_REQS[v], $sformatf("R4 request count vector %0d", v),
                  req_cnt - req_base, VEC_REQS[v]);
        end

        // R3: a single short gate is forgiven
        req_base  = req_cnt;
        rise_base = rise_cnt;
        rec_stop = 1'b1;
        #(30.0 * REF_PERIOD);
        rec_stop = 1'b0;
        wait_ref(SETTLE);
        check(rise_cnt == rise_base, "R3 lone bad gate no alarm", rise_cnt - rise_base, 0);
        check(req_cnt == req_base, "R3 lone bad gate no request", req_cnt - req_base, 0);

        // R8: stopped recovered clock
        req_base = req_cnt;
        stop_cyc = cyc;
        rec_stop = 1'b1;
        wait_ref(SETTLE);
        check(lock_lost == 1'b1, "R8 stopped clock alarm", int'(lock_lost), 1);
        check(rise_cyc - stop_cyc >= 250, "R8 alarm delay after stop", rise_cyc - stop_cyc, 250);
        check(req_cnt - req_base == 1, "R4 one request on stop", req_cnt - req_base, 1);

        // R6: release when the clock returns
        rec_stop = 1'b0;
        wait_ref(SETTLE);
        check(lock_lost == 1'b0, "R6 release after clock returns", int'(lock_lost), 0);

        // R5: every completed alarm lasted at least the minimum width
        check(min_width >= 32, "R5 minimum alarm width", min_width, 32);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge ref_clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule